// File: doc/BRIEF.md
# Backlight PWM Modulator

This block drives a panel backlight with a pulse-width-modulated signal. Software writes one 32-bit control word that carries an enable flag, a modulation period and an on-time. A clock-enable input, `cyc_en`, marks each backlight cycle. The block counts those cycles inside each modulation period. The output is high for the programmed on-time at the start of every period and low for the rest of it.

The period field holds only the upper bits of the cycle count, so the real period is twice the written value. The on-time is a full 16-bit count. If it is larger than the doubled period, the output stays high for the whole period. New period and on-time values are first kept in a shadow copy. They replace the running values only when the counter wraps, so a change can never produce a shortened or stretched period. When modulation is stopped, a written value takes effect at once.

Top module: `bl_pwm_mod`

## Requirements
- R1: The period field sits at control-word bits 31:17. A modulation period lasts twice that field value in `cyc_en` ticks. The internal count then wraps to zero and a new period starts.
- R2: The duty field sits at control-word bits 15:0. In each period the output is high while the tick count within the period is below the duty value, and low otherwise.
- R3: A duty value greater than or equal to twice the period field keeps the output high for the entire period.
- R4: A duty value of zero keeps the output low for the entire period.
- R5: The enable flag sits at control-word bit 16. Writing it as 0 drives the output low from the cycle after the write and returns the count to zero. A later write with the flag set starts a fresh period at count zero.
- R6: A period field of zero keeps the output low and holds the count at zero, whatever the duty value and the enable flag.
- R7: While modulating, newly written period and duty values take effect only at the next wrap. When not modulating, they take effect at the write.
- R8: In a cycle where `cyc_en` is low, the count and the output hold their values.
- R9: Reset drives the output low and clears the enable flag, the period and the duty. The output stays low after reset until a write arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control-word write strobe, one cycle per write |
| cfg_wdata | input | 32 | Control word: period at bits 31:17, enable at bit 16, duty at bits 15:0 |
| cyc_en | input | 1 | Backlight cycle tick; the count advances only in cycles where it is high |
| pwm_out | output | 1 | Modulated backlight output |

## Verification
Several properties are checked on every cycle: the output is low whenever modulation is disabled, the period is zero or the duty is zero; it is high for the whole period when the duty meets or exceeds the doubled period; the count stays inside the period and returns to zero after a wrap; and the running values stay fixed between wraps while no tick is lost. Other behaviours need whole scenarios, so only the bench's sequences can show them. These are the exact number of high cycles per period across a table of period and duty pairs, the deferral of a mid-period rewrite until the wrap, a restart at count zero after re-enabling, and the holding of the waveform across gaps in `cyc_en`.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
   // Default layout of the control word and field widths.
   localparam int unsigned BL_WORD_W  = 32;
   localparam int unsigned BL_PER_W   = 15;
   localparam int unsigned BL_DUTY_W  = 16;
   localparam int unsigned BL_PER_LSB = 17;
   localparam int unsigned BL_EN_BIT  = 16;
endpackage

// File: rtl/bl_pwm_regs.sv
// Shadow and active copies of the modulation settings.
module bl_pwm_regs #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned PER_W   = 15,
   parameter int unsigned DUTY_W  = 16,
   parameter int unsigned PER_LSB = 17,
   parameter int unsigned EN_BIT  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WORD_W-1:0] wdata,
   input  logic              load,
   output logic              en_q,
   output logic [PER_W-1:0]  act_per,
   output logic [DUTY_W-1:0] act_duty
);
   logic [PER_W-1:0]  shd_per;
   logic [DUTY_W-1:0] shd_duty;
   logic [PER_W-1:0]  per_nxt;
   logic [DUTY_W-1:0] duty_nxt;

   // A write in the same cycle as a load goes straight through.
   always_comb begin
      per_nxt  = we ? wdata[PER_LSB +: PER_W] : shd_per;
      duty_nxt = we ? wdata[DUTY_W-1:0]       : shd_duty;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         shd_per  <= '0;
         shd_duty <= '0;
         act_per  <= '0;
         act_duty <= '0;
      end else begin
         if (we) begin
            en_q     <= wdata[EN_BIT];
            shd_per  <= per_nxt;
            shd_duty <= duty_nxt;
         end
         if (load) begin
            act_per  <= per_nxt;
            act_duty <= duty_nxt;
         end
      end
   end
endmodule

// File: rtl/bl_pwm_counter.sv
// Position counter within the modulation period.
module bl_pwm_counter #(
   parameter int unsigned PER_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [PER_W-1:0] act_per,
   output logic [PER_W:0]   cnt,
   output logic             wrap
);
   localparam int unsigned CNT_W = PER_W + 1;

   logic [CNT_W-1:0] last;

   assign last = {act_per, 1'b0} - CNT_W'(1);
   assign wrap = run && tick && (cnt == last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= wrap ? '0 : cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/bl_pwm_compare.sv
// Clamps the duty to the doubled period and forms the output.
module bl_pwm_compare #(
   parameter int unsigned PER_W  = 15,
   parameter int unsigned DUTY_W = 16
) (
   input  logic              run,
   input  logic [PER_W:0]    cnt,
   input  logic [PER_W-1:0]  act_per,
   input  logic [DUTY_W-1:0] act_duty,
   output logic              hi
);
   localparam int unsigned CNT_W = PER_W + 1;
   localparam int unsigned CMP_W = (CNT_W > DUTY_W) ? CNT_W : DUTY_W;

   logic [CMP_W-1:0] cnt_x;
   logic [CMP_W-1:0] span_x;
   logic [CMP_W-1:0] duty_x;
   logic [CMP_W-1:0] limit;

   // Bring the count and the duty to one compare width.
   if (CNT_W == DUTY_W) begin : g_same_w
      assign cnt_x  = cnt;
      assign span_x = {act_per, 1'b0};
      assign duty_x = act_duty;
   end else if (CNT_W > DUTY_W) begin : g_cnt_wide
      assign cnt_x  = cnt;
      assign span_x = {act_per, 1'b0};
      assign duty_x = {{(CMP_W-DUTY_W){1'b0}}, act_duty};
   end else begin : g_duty_wide
      assign cnt_x  = {{(CMP_W-CNT_W){1'b0}}, cnt};
      assign span_x = {{(CMP_W-CNT_W){1'b0}}, act_per, 1'b0};
      assign duty_x = act_duty;
   end

   assign limit = (duty_x > span_x) ? span_x : duty_x;
   assign hi    = run && (cnt_x < limit);
endmodule

// File: rtl/bl_pwm_mod.sv
// Backlight PWM modulator top level.
module bl_pwm_mod
   import bl_pwm_pkg::*;
#(
   parameter int unsigned WORD_W  = BL_WORD_W,
   parameter int unsigned PER_W   = BL_PER_W,
   parameter int unsigned DUTY_W  = BL_DUTY_W,
   parameter int unsigned PER_LSB = BL_PER_LSB,
   parameter int unsigned EN_BIT  = BL_EN_BIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              cyc_en,
   output logic              pwm_out
);
   localparam int unsigned CNT_W = PER_W + 1;

   // Elaboration-time checks on the control-word layout.
   if (PER_LSB + PER_W > WORD_W) begin : g_bad_per
      $error("period field exceeds the control word");
   end
   if (DUTY_W > EN_BIT || EN_BIT >= PER_LSB) begin : g_bad_layout
      $error("enable bit must lie between duty and period fields");
   end
   if (PER_W < 1 || DUTY_W < 1) begin : g_bad_w
      $error("field widths must be non-zero");
   end

   logic              en_q;
   logic [PER_W-1:0]  act_per;
   logic [DUTY_W-1:0] act_duty;
   logic [CNT_W-1:0]  cnt;
   logic              run;
   logic              wrap;
   logic              load;

   assign run  = en_q && (act_per != '0);
   assign load = !run || wrap;

   bl_pwm_regs #(
      .WORD_W (WORD_W),
      .PER_W  (PER_W),
      .DUTY_W (DUTY_W),
      .PER_LSB(PER_LSB),
      .EN_BIT (EN_BIT)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .wdata   (cfg_wdata),
      .load    (load),
      .en_q    (en_q),
      .act_per (act_per),
      .act_duty(act_duty)
   );

   bl_pwm_counter #(
      .PER_W(PER_W)
   ) u_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .tick   (cyc_en),
      .act_per(act_per),
      .cnt    (cnt),
      .wrap   (wrap)
   );

   bl_pwm_compare #(
      .PER_W (PER_W),
      .DUTY_W(DUTY_W)
   ) u_compare (
      .run     (run),
      .cnt     (cnt),
      .act_per (act_per),
      .act_duty(act_duty),
      .hi      (pwm_out)
   );
endmodule

// File: rtl/bl_pwm_mod_chk.sv
// Property checker attached to the modulator.
module bl_pwm_mod_chk #(
   parameter int unsigned PER_W  = 15,
   parameter int unsigned DUTY_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic              cyc_en,
   input logic              pwm_out,
   input logic              en_q,
   input logic              run,
   input logic              wrap,
   input logic [PER_W-1:0]  act_per,
   input logic [DUTY_W-1:0] act_duty,
   input logic [PER_W:0]    cnt
);
   p_low_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !pwm_out);

   p_zero_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_per == '0) |-> (!pwm_out && cnt == '0));

   p_zero_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_duty == '0) |-> !pwm_out);

   p_full_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && 32'(act_duty) >= 32'({act_per, 1'b0})) |-> pwm_out);

   p_cnt_in_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (act_per != '0) |-> (32'(cnt) < 32'({act_per, 1'b0})));

   p_wrap_to_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));

   p_hold_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wrap) |=> ($stable(act_per) && $stable(act_duty)));

   p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cyc_en && !cfg_we) |=> ($stable(cnt) && $stable(pwm_out)));
endmodule

bind bl_pwm_mod bl_pwm_mod_chk #(
   .PER_W (PER_W),
   .DUTY_W(DUTY_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cfg_we  (cfg_we),
   .cyc_en  (cyc_en),
   .pwm_out (pwm_out),
   .en_q    (en_q),
   .run     (run),
   .wrap    (wrap),
   .act_per (act_per),
   .act_duty(act_duty),
   .cnt     (cnt)
);

// File: tb/bl_pwm_mod_bench.sv
module bl_pwm_mod_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;

   localparam logic [14:0] V_PER  [NV] = '{15'd4, 15'd4, 15'd4, 15'd1,
                                           15'd3, 15'd0, 15'd5, 15'd2};
   localparam logic [15:0] V_DUTY [NV] = '{16'd3, 16'd8, 16'd20, 16'd1,
                                           16'd0, 16'd5, 16'd9, 16'hFFFF};
   localparam int          V_EXP  [NV] = '{6, 16, 16, 2, 0, 0, 18, 8};
   localparam string       V_REQ  [NV] = '{"R2", "R3", "R3", "R1",
                                           "R4", "R6", "R2", "R3"};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        cyc_en = 1'b1;
   logic        pwm_out;

   int n_chk = 0;
   int n_fail = 0;

   bl_pwm_mod u_bl_pwm_mod (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_wdata(cfg_wdata),
      .cyc_en   (cyc_en),
      .pwm_out  (pwm_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Called at a falling edge; the write is taken at the next rising edge.
   task automatic wr(input logic en, input logic [14:0] per, input logic [15:0] duty);
      cfg_we    = 1'b1;
      cfg_wdata = {per, en, duty};
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic measure(input int n, output int hi);
      hi = 0;
      repeat (n) begin
         if (pwm_out) hi++;
         @(negedge clk);
      end
   endtask

   task automatic capture(input int n, output int bits);
      bits = 0;
      for (int k = 0; k < n; k++) begin
         if (pwm_out) bits |= (1 << k);
         @(negedge clk);
      end
   endtask

   initial begin
      int h;
      int b;
      repeat (3) @(negedge clk);
      check("R9", int'(pwm_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      measure(4, h);
      check("R9", h, 0);

      // Table of period/duty settings, two periods each.
      for (int i = 0; i < NV; i++) begin
         int win;
         win = (V_PER[i] == 0) ? 16 : 4 * int'(V_PER[i]);
         wr(1'b0, 15'd0, 16'd0);
         wr(1'b1, V_PER[i], V_DUTY[i]);
         measure(win, h);
         check(V_REQ[i], h, V_EXP[i]);
      end

      // R1: period of 6 ticks, duty 1: high at tick 0 and tick 6.
      wr(1'b0, 15'd0, 16'd0);
      wr(1'b1, 15'd3, 16'd1);
      capture(7, b);
      check("R1", b, 32'h41);

      // R7: mid-period rewrite waits for the wrap.
      wr(1'b0, 15'd0, 16'd0);
      wr(1'b1, 15'd4, 16'd2);
      measure(2, h);
      check("R7", h, 2);
      wr(1'b1, 15'd2, 16'd4);
      measure(5, h);
      check("R7", h, 0);
      measure(8, h);
      check("R7", h, 8);

      // R5: clearing enable forces low; re-enable restarts at zero.
      wr(1'b0, 15'd2, 16'd4);
      measure(6, h);
      check("R5", h, 0);
      wr(1'b1, 15'd2, 16'd1);
      capture(5, b);
      check("R5", b, 32'h11);

      // R8: no ticks means the waveform holds.
      wr(1'b0, 15'd0, 16'd0);
      cyc_en = 1'b0;
      wr(1'b1, 15'd2, 16'd1);
      capture(6, b);
      check("R8", b, 32'h3F);
      cyc_en = 1'b1;
      @(negedge clk);
      check("R8", int'(pwm_out), 0);
      capture(4, b);
      check("R8", b, 32'h8);

      // R9: reset while running clears everything.
      wr(1'b0, 15'd0, 16'd0);
      wr(1'b1, 15'd2, 16'd4);
      rst_n = 1'b0;
      @(negedge clk);
      check("R9", int'(pwm_out), 0);
      rst_n = 1'b1;
      measure(6, h);
      check("R9", h, 0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule